// File: doc/BRIEF.md
# Scatter-Gather Task List Sequencer

This block gives one DMA channel a chained mode of operation. Software places a list of task entries in memory, each four 32-bit words long: the last source word address, the last destination word address, a control word, and a spare word that is read but not kept. After a start pulse the sequencer alternates between two phases. In the fetch phase a primary counter, loaded with four words per task, copies the next entry from memory into a small alternate descriptor store. In the execute phase that stored descriptor drives a word copy loop over the same memory port. A task whose mode is one of the chaining modes hands control back to the fetch phase. A plain basic or auto task ends the chain and releases the channel.

Memory is reached through one word-wide port with a read latency of one cycle. Peripheral-paced tasks wait for a request input before they move any data. The phase and the index of the active task are visible at all times. A list that runs out while its last task still asks for chaining stops the channel with an error flag.

Top module: `sg_task_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`=0, `phase`=0 (idle), `err`=0, `done`=0, and neither `mem_rd` nor `mem_we` is asserted.
- R2: Fetching task i issues four single reads, in order, at byte addresses `list_base + 16*i + 4*k` for k = 0..3, with `phase`=1 (fetch) and `task_idx`=i. Each completed fetch lowers the primary word count by four.
- R3: Control word layout: bits [2:0] mode, bit 3 burst-only, bits [13:4] item count minus one, bit 30 source hold, bit 31 destination hold. Executing a task copies that many words. Each word is read from the source and then written unchanged to the destination. Addresses start at the end pointer minus 4*(count-1) and step by 4, or stay on the end pointer when the hold bit is set.
- R4: Tasks run strictly in list order. After a task with mode bit 2 set (modes 4 to 7) finishes, the sequencer fetches entry i+1. `task_idx` advances by one and `phase` reads 2 (execute) during its data accesses.
- R5: A task with mode 1 (basic) or 2 (auto) ends the chain. `done` pulses for exactly one cycle, `busy` falls, and `err` stays 0.
- R6: Modes 1, 6 and 7 wait for a request before the first access of the task; modes 2, 4 and 5 start without one.
- R7: When the burst-only bit is set, a waiting task ignores `req_single` and starts only on `req_burst`. When the bit is clear, either request starts it.
- R8: If a chaining task finishes after the last listed entry has been fetched, the channel stops with `err`=1 and no `done` pulse.
- R9: A fetched task with mode 0 or 3 stops the channel with `err`=1 before any data access.
- R10: A start with `task_total`=0 sets `err` and makes no memory access.
- R11: A start pulse while `busy`=1 has no effect on the running chain.
- R12: `err` holds its value while idle and is cleared by the next accepted start with a non-zero task count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a chain when idle |
| list_base | input | 32 | Byte address of the first task entry |
| task_total | input | TASK_W | Number of entries in the list |
| req_single | input | 1 | Single-item request from the paced peripheral |
| req_burst | input | 1 | Burst request from the paced peripheral |
| mem_rd | output | 1 | Memory read strobe; data returns in the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| busy | output | 1 | Channel enabled and working on a chain |
| phase | output | 2 | 0 idle, 1 fetch, 2 execute |
| task_idx | output | TASK_W | Index of the entry being fetched or executed |
| done | output | 1 | One-cycle pulse when a chain ends normally |
| err | output | 1 | Sticky error from an exhausted list, illegal mode or empty start |

## Verification
A memory-paced chain of three tasks mixes incrementing, held-source and held-destination copies and ends in auto mode. Its bus trace against the behavioural model separates correct address stepping and list ordering from off-by-one counts and swapped hold bits. A stray start pulse is driven in the middle of that chain. A peripheral-paced chain first withholds its requests and then offers only single requests to a burst-only task, which shows whether the wait and the burst qualification are honoured. One-entry lists that end in chaining mode, an entry with an illegal mode and an empty start each stop the channel differently. Comparing the err, done and access counts across these cases tells the three stop paths apart.

// File: rtl/sgseq_pkg.sv
package sgseq_pkg;
  localparam int WORD_W      = 32;
  localparam int ENTRY_WORDS = 4;
  localparam int KEPT_WORDS  = 3;
  localparam int CNT_LSB     = 4;
  localparam int CNT_W       = 10;
  localparam int BURST_BIT   = 3;
  localparam int SRC_HOLD    = 30;
  localparam int DST_HOLD    = 31;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W:0]    items_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_EXEC  = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FADDR, ST_FDATA, ST_XCHK, ST_XRD, ST_XWR
  } state_e;

  function automatic logic [2:0] mode_of(word_t ctl);
    return ctl[2:0];
  endfunction

  function automatic items_t item_count(word_t ctl);
    return items_t'(ctl[CNT_LSB +: CNT_W]) + items_t'(1);
  endfunction

  function automatic word_t first_addr(word_t end_ptr, logic hold, items_t n);
    if (hold) return end_ptr;
    return end_ptr - (word_t'(n - items_t'(1)) << 2);
  endfunction

  function automatic logic mode_legal(logic [2:0] m);
    return (m != 3'd0) && (m != 3'd3);
  endfunction

  function automatic logic mode_chains(logic [2:0] m);
    return m[2];
  endfunction

  function automatic logic mode_waits(logic [2:0] m);
    return (m == 3'd1) || (m[2] && m[1]);
  endfunction

  function automatic word_t entry_addr(word_t base, word_t idx, logic [1:0] k);
    return base + (idx << 4) + (word_t'(k) << 2);
  endfunction
endpackage

// File: rtl/sg_desc_store.sv
module sg_desc_store
  import sgseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  word_t      wr_data,
  output word_t      src_end,
  output word_t      dst_end,
  output word_t      ctl
);
  word_t slot_w [KEPT_WORDS];

  generate
    for (genvar g = 0; g < KEPT_WORDS; g++) begin : g_slot
      word_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en && (wr_sel == 2'(g))) q <= wr_data;
      end
      assign slot_w[g] = q;
    end
  endgenerate

  assign src_end = slot_w[0];
  assign dst_end = slot_w[1];
  assign ctl     = slot_w[2];
endmodule

// File: rtl/sg_prim_ctr.sv
module sg_prim_ctr
  import sgseq_pkg::*;
#(
  parameter int TASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TASK_W-1:0] total,
  input  logic              fetch_done,
  input  logic              next_task,
  output logic              list_empty,
  output logic [TASK_W-1:0] idx
);
  localparam int LEFT_W = TASK_W + 2;

  logic [LEFT_W-1:0] words_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_left <= '0;
      idx        <= '0;
    end else if (load) begin
      words_left <= {total, 2'b00};
      idx        <= '0;
    end else begin
      if (fetch_done) words_left <= words_left - LEFT_W'(ENTRY_WORDS);
      if (next_task)  idx        <= idx + TASK_W'(1);
    end
  end

  assign list_empty = (words_left == '0);

  assert_prim_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> words_left == $past(words_left) - LEFT_W'(ENTRY_WORDS));

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |-> words_left >= LEFT_W'(ENTRY_WORDS));
endmodule

// File: rtl/sg_copy_engine.sv
module sg_copy_engine
  import sgseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  word_t  src_start,
  input  word_t  dst_start,
  input  logic   src_hold,
  input  logic   dst_hold,
  input  items_t n_items,
  input  logic   step,
  output word_t  src_addr,
  output word_t  dst_addr,
  output logic   last_item
);
  items_t rem_q;
  logic   src_hold_q, dst_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q      <= '0;
      src_addr   <= '0;
      dst_addr   <= '0;
      src_hold_q <= 1'b0;
      dst_hold_q <= 1'b0;
    end else if (load) begin
      rem_q      <= n_items;
      src_addr   <= src_start;
      dst_addr   <= dst_start;
      src_hold_q <= src_hold;
      dst_hold_q <= dst_hold;
    end else if (step) begin
      rem_q <= rem_q - items_t'(1);
      if (!src_hold_q) src_addr <= src_addr + word_t'(4);
      if (!dst_hold_q) dst_addr <= dst_addr + word_t'(4);
    end
  end

  assign last_item = (rem_q == items_t'(1));

  assert_copy_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> rem_q != '0);

  assert_load_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> n_items != '0);
endmodule

// File: rtl/sg_task_sequencer.sv
module sg_task_sequencer
  import sgseq_pkg::*;
#(
  parameter int TASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       list_base,
  input  logic [TASK_W-1:0] task_total,
  input  logic              req_single,
  input  logic              req_burst,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic [1:0]        phase,
  output logic [TASK_W-1:0] task_idx,
  output logic              done,
  output logic              err
);
  state_e     state_q, state_d;
  logic [1:0] slot_q;
  word_t      base_q;
  logic       err_q, done_q;

  word_t       src_end, dst_end, ctl;
  word_t       src_addr, dst_addr;
  logic        last_item, list_empty;
  logic [TASK_W-1:0] idx;
  logic [2:0]  mode;
  items_t      n_items;
  logic        req_ok;

  // named events for the assertions and the state update
  logic ev_start_ok, ev_start_zero, ev_fetch_last, ev_mode_bad;
  logic ev_launch, ev_item, ev_task_end, ev_chain_next, ev_exhaust, ev_finish;

  assign mode    = mode_of(ctl);
  assign n_items = item_count(ctl);
  assign req_ok  = req_burst || (req_single && !ctl[BURST_BIT]);

  assign ev_start_ok   = (state_q == ST_IDLE) && start && (task_total != '0);
  assign ev_start_zero = (state_q == ST_IDLE) && start && (task_total == '0);
  assign ev_fetch_last = (state_q == ST_FDATA) && (slot_q == 2'd3);
  assign ev_mode_bad   = (state_q == ST_XCHK) && !mode_legal(mode);
  assign ev_launch     = (state_q == ST_XCHK) && mode_legal(mode) &&
                         (!mode_waits(mode) || req_ok);
  assign ev_item       = (state_q == ST_XWR);
  assign ev_task_end   = ev_item && last_item;
  assign ev_chain_next = ev_task_end && mode_chains(mode) && !list_empty;
  assign ev_exhaust    = ev_task_end && mode_chains(mode) && list_empty;
  assign ev_finish     = ev_task_end && !mode_chains(mode);

  sg_prim_ctr #(.TASK_W(TASK_W)) u_prim (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ev_start_ok),
    .total      (task_total),
    .fetch_done (ev_fetch_last),
    .next_task  (ev_chain_next),
    .list_empty (list_empty),
    .idx        (idx)
  );

  sg_desc_store u_desc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (state_q == ST_FDATA),
    .wr_sel  (slot_q),
    .wr_data (mem_rdata),
    .src_end (src_end),
    .dst_end (dst_end),
    .ctl     (ctl)
  );

  sg_copy_engine u_copy (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_launch),
    .src_start (first_addr(src_end, ctl[SRC_HOLD], n_items)),
    .dst_start (first_addr(dst_end, ctl[DST_HOLD], n_items)),
    .src_hold  (ctl[SRC_HOLD]),
    .dst_hold  (ctl[DST_HOLD]),
    .n_items   (n_items),
    .step      (ev_item),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .last_item (last_item)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ev_start_ok) state_d = ST_FADDR;
      ST_FADDR: state_d = ST_FDATA;
      ST_FDATA: state_d = ev_fetch_last ? ST_XCHK : ST_FADDR;
      ST_XCHK: begin
        if (ev_mode_bad)    state_d = ST_IDLE;
        else if (ev_launch) state_d = ST_XRD;
      end
      ST_XRD:   state_d = ST_XWR;
      ST_XWR: begin
        if (ev_chain_next)               state_d = ST_FADDR;
        else if (ev_exhaust || ev_finish) state_d = ST_IDLE;
        else                              state_d = ST_XRD;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      base_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= ev_finish;
      if (ev_start_ok) begin
        base_q <= list_base;
        slot_q <= '0;
        err_q  <= 1'b0;
      end
      if (ev_start_zero || ev_mode_bad || ev_exhaust) err_q <= 1'b1;
      if (state_q == ST_FDATA) slot_q <= slot_q + 2'd1;
      if (ev_chain_next)       slot_q <= '0;
    end
  end

  always_comb begin
    mem_addr = '0;
    unique case (state_q)
      ST_FADDR: mem_addr = entry_addr(base_q, word_t'(idx), slot_q);
      ST_XRD:   mem_addr = src_addr;
      ST_XWR:   mem_addr = dst_addr;
      default:  mem_addr = '0;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE:            phase = PH_IDLE;
      ST_FADDR, ST_FDATA: phase = PH_FETCH;
      default:            phase = PH_EXEC;
    endcase
  end

  assign mem_rd    = (state_q == ST_FADDR) || (state_q == ST_XRD);
  assign mem_we    = (state_q == ST_XWR);
  assign mem_wdata = mem_rdata;
  assign busy      = (state_q != ST_IDLE);
  assign task_idx  = idx;
  assign done      = done_q;
  assign err       = err_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd && !mem_we);

  assert_write_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_rd));

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (task_idx != $past(task_idx)))
      |-> task_idx == $past(task_idx) + TASK_W'(1));

  assert_done_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !err);

  assert_wait_no_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_XCHK) && mode_waits(mode) && !req_single && !req_burst)
      |=> !mem_rd);

  assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && !done);

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(base_q));
endmodule

// File: tb/sim_sg_task_sequencer.sv
module sim_sg_task_sequencer;
  localparam int TASK_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       list_base = '0;
  logic [TASK_W-1:0] task_total = '0;
  logic              req_single = 1'b0;
  logic              req_burst = 1'b0;
  logic              mem_rd, mem_we;
  logic [31:0]       mem_addr, mem_wdata;
  logic [31:0]       mem_rdata = '0;
  logic              busy, done, err;
  logic [1:0]        phase;
  logic [TASK_W-1:0] task_idx;

  int checks = 0;
  int errors = 0;
  int ops = 0;
  int done_cycles = 0;
  int cyc = 0;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    int          idx;
    bit          fetch;
  } op_t;
  op_t exp_q[$];
  op_t cur;

  logic [31:0] mem [256];

  always #4 clk = ~clk;

  sg_task_sequencer #(.TASK_W(TASK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
    .task_total(task_total), .req_single(req_single), .req_burst(req_burst),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .phase(phase), .task_idx(task_idx),
    .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus trace compared against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cycles++;
      if (mem_rd || mem_we) begin
        ops++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 access not in model", mem_addr, 32'h0);
        end else begin
          cur = exp_q.pop_front();
          chk(mem_we == cur.we, cur.fetch ? "R2 strobe" : "R3 strobe",
              32'(mem_we), 32'(cur.we));
          chk(mem_addr == cur.addr, cur.fetch ? "R2 address" : "R3 address",
              mem_addr, cur.addr);
          if (cur.we) chk(mem_wdata == cur.data, "R3 data", mem_wdata, cur.data);
          chk(32'(task_idx) == 32'(cur.idx), "R4 task index",
              32'(task_idx), 32'(cur.idx));
          chk(phase == (cur.fetch ? 2'd1 : 2'd2), "R4 phase",
              32'(phase), cur.fetch ? 32'd1 : 32'd2);
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] ctlw(input int mode, input bit burst, input int n,
                                       input bit shold, input bit dhold);
    return {dhold, shold, 16'h0, 10'(n - 1), burst, 3'(mode)};
  endfunction

  task automatic put_task(input logic [31:0] base, input int i, input logic [31:0] se,
                          input logic [31:0] de, input logic [31:0] c);
    logic [31:0] a;
    a = base + 32'(16 * i);
    mem[a[9:2]]         = se;
    mem[a[9:2] + 8'd1]  = de;
    mem[a[9:2] + 8'd2]  = c;
    mem[a[9:2] + 8'd3]  = 32'hDEAD_0000 + 32'(i);
  endtask

  task automatic build_expect(input logic [31:0] base, input int ntasks);
    for (int i = 0; i < ntasks; i++) begin
      logic [31:0] c, s, d, ea;
      int m, n;
      for (int k = 0; k < 4; k++)
        exp_q.push_back('{we: 1'b0, addr: base + 32'(16 * i + 4 * k), data: 32'h0,
                          idx: i, fetch: 1'b1});
      ea = base + 32'(16 * i);
      c  = mem[ea[9:2] + 8'd2];
      m  = int'(c[2:0]);
      if (m == 0 || m == 3) return;
      n = int'(c[13:4]) + 1;
      s = mem[ea[9:2]];
      d = mem[ea[9:2] + 8'd1];
      if (!c[30]) s = s - 32'(4 * (n - 1));
      if (!c[31]) d = d - 32'(4 * (n - 1));
      for (int j = 0; j < n; j++) begin
        exp_q.push_back('{we: 1'b0, addr: s, data: 32'h0, idx: i, fetch: 1'b0});
        exp_q.push_back('{we: 1'b1, addr: d, data: mem[s[9:2]], idx: i, fetch: 1'b0});
        if (!c[30]) s = s + 32'd4;
        if (!c[31]) d = d + 32'd4;
      end
      if (m < 4) return;
    end
  endtask

  task automatic do_start(input logic [31:0] base, input int total);
    @(negedge clk);
    start      = 1'b1;
    list_base  = base;
    task_total = TASK_W'(total);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 5000; t++) begin
      if (!busy) return;
      @(negedge clk);
    end
    chk(1'b0, "R5 chain never ended", 32'(busy), 32'h0);
  endtask

  task automatic wait_exec(input int i);
    for (int t = 0; t < 5000; t++) begin
      if (phase == 2'd2 && 32'(task_idx) == 32'(i)) return;
      @(negedge clk);
    end
    chk(1'b0, "R4 execute phase never reached", 32'(task_idx), 32'(i));
  endtask

  initial begin
    int ops0, dc0;
    for (int w = 0; w < 256; w++) mem[w] = 32'h0;
    for (int w = 64; w < 128; w++) mem[w] = 32'hC0DE_0000 + 32'(w * 32'h0101);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && phase == 2'd0, "R1 idle after reset", 32'(phase), 32'h0);
    chk(err == 1'b0 && done == 1'b0, "R1 flags after reset", {err, done}, 32'h0);
    chk(!mem_rd && !mem_we, "R1 no access after reset", {mem_rd, mem_we}, 32'h0);

    // memory-paced chain of three tasks, last in auto mode
    put_task(32'h000, 0, 32'h108, 32'h208, ctlw(5, 0, 3, 0, 0));
    put_task(32'h000, 1, 32'h110, 32'h214, ctlw(5, 0, 2, 1, 0));
    put_task(32'h000, 2, 32'h12C, 32'h220, ctlw(2, 0, 4, 0, 1));
    put_task(32'h040, 0, 32'h130, 32'h230, ctlw(1, 0, 1, 0, 0));
    build_expect(32'h000, 3);
    dc0 = done_cycles;
    do_start(32'h000, 3);
    repeat (10) @(negedge clk);
    do_start(32'h040, 1);   // R11: ignored while the chain runs
    list_base = 32'h0;
    wait_idle();
    @(negedge clk);
    chk(exp_q.size() == 0, "R4 R11 all modelled accesses seen", 32'(exp_q.size()), 32'h0);
    chk(done_cycles == dc0 + 1, "R5 one done pulse", 32'(done_cycles - dc0), 32'h1);
    chk(err == 1'b0, "R5 no error on normal end", 32'(err), 32'h0);
    chk(busy == 1'b0 && phase == 2'd0, "R5 channel released", 32'(phase), 32'h0);
    chk(mem[32'h208 >> 2] == mem[32'h108 >> 2], "R3 last incrementing word",
        mem[32'h208 >> 2], mem[32'h108 >> 2]);
    chk(mem[32'h220 >> 2] == mem[32'h12C >> 2], "R3 held destination keeps last",
        mem[32'h220 >> 2], mem[32'h12C >> 2]);
    chk(mem[32'h214 >> 2] == mem[32'h110 >> 2], "R3 held source",
        mem[32'h214 >> 2], mem[32'h110 >> 2]);
    chk(done_cycles == dc0 + 1, "R6 memory and auto modes ran without request",
        32'(done_cycles - dc0), 32'h1);

    // empty start
    ops0 = ops;
    do_start(32'h000, 0);
    chk(err == 1'b1 && busy == 1'b0, "R10 empty start flags error", {err, busy}, 32'h2);
    repeat (6) @(negedge clk);
    chk(ops == ops0, "R10 no access on empty start", 32'(ops - ops0), 32'h0);
    chk(err == 1'b1, "R12 error held while idle", 32'(err), 32'h1);

    // list exhausted while the last task still chains
    put_task(32'h040, 0, 32'h134, 32'h234, ctlw(5, 0, 1, 0, 0));
    build_expect(32'h040, 1);
    dc0 = done_cycles;
    do_start(32'h040, 1);
    chk(err == 1'b0 && busy == 1'b1, "R12 start clears error", {err, busy}, 32'h1);
    wait_idle();
    @(negedge clk);
    chk(err == 1'b1, "R8 exhausted list sets error", 32'(err), 32'h1);
    chk(done_cycles == dc0, "R8 no done pulse", 32'(done_cycles - dc0), 32'h0);
    chk(exp_q.size() == 0, "R8 accesses up to the stop", 32'(exp_q.size()), 32'h0);

    // illegal mode in the second entry
    put_task(32'h080, 0, 32'h138, 32'h238, ctlw(4, 0, 1, 0, 0));
    put_task(32'h080, 1, 32'h13C, 32'h23C, ctlw(3, 0, 2, 0, 0));
    build_expect(32'h080, 2);
    do_start(32'h080, 2);
    wait_idle();
    @(negedge clk);
    chk(err == 1'b1, "R9 illegal mode sets error", 32'(err), 32'h1);
    chk(exp_q.size() == 0, "R9 no data access for illegal task", 32'(exp_q.size()), 32'h0);

    // peripheral-paced chain, first task burst-only
    put_task(32'h0C0, 0, 32'h144, 32'h244, ctlw(7, 1, 2, 0, 0));
    put_task(32'h0C0, 1, 32'h150, 32'h250, ctlw(1, 0, 1, 0, 0));
    build_expect(32'h0C0, 2);
    dc0 = done_cycles;
    do_start(32'h0C0, 2);
    wait_exec(0);
    ops0 = ops;
    repeat (12) @(negedge clk);
    chk(ops == ops0, "R6 peripheral task waits for request", 32'(ops - ops0), 32'h0);
    req_single = 1'b1;
    repeat (12) @(negedge clk);
    chk(ops == ops0, "R7 single request ignored by burst-only task",
        32'(ops - ops0), 32'h0);
    req_single = 1'b0;
    req_burst  = 1'b1;
    @(negedge clk);
    req_burst  = 1'b0;
    wait_exec(1);
    ops0 = ops;
    repeat (8) @(negedge clk);
    chk(ops == ops0, "R6 basic task waits for request", 32'(ops - ops0), 32'h0);
    req_single = 1'b1;
    @(negedge clk);
    req_single = 1'b0;
    wait_idle();
    @(negedge clk);
    chk(done_cycles == dc0 + 1, "R7 single request accepted when flag clear",
        32'(done_cycles - dc0), 32'h1);
    chk(exp_q.size() == 0 && err == 1'b0, "R4 peripheral chain complete",
        32'(exp_q.size()), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule